// File: doc/BRIEF.md
# Pooled Multi-Mode DMA Channel Controller

This block moves byte or word data over a simple memory bus. Its register pool is one set of storage that serves in either of two layouts. When `long_mode` is low, the pool forms four channels. Each of these channels has an 8-bit source offset and a 24-bit destination. The offset selects a byte inside a fixed 256-byte peripheral window, whose upper 16 address bits come from the `PERIPH_HI` parameter. When `long_mode` is high, the same storage forms two channels with full 24-bit source and destination addresses. For each long channel, the destination field of the odd slot beside it holds the source address.

Software programs a channel through a plain write port, sets its enable bit, and then holds that channel's `req` line high. Every enabled channel that is requesting is served in fixed priority, with channel 0 highest, and each grant issues one move command on the bus. Each channel has a 16-bit transfer count. A count of zero is taken as 65536.

The bus side is a valid/ready output stream. A command is presented with `mem_valid`. The command stays fixed until the bus raises `mem_ready`. The move counts as complete on the clock edge where both signals are high. The bus may hold `mem_ready` low for any number of cycles, and the block waits for as long as it is held. Arbitration happens only while no command is outstanding. The layout input `long_mode` may change only while every channel is idle.

Top module: `dmac_pool`

## Requirements
- R1: After reset, `mem_valid` is 0, `done` is 0 and every channel is disabled.
- R2: A write with `cfg_we` high stores `cfg_data` into the field that `cfg_field` selects (0 source, 1 destination, 2 count, 3 control) of logical channel `cfg_ch`. The value is also saved as the channel's start value. The control bits are [0] enable, [1] word size, [2] source fixed, [3] destination fixed and [4] repeat. A control write clears that channel's `done` bit.
- R3: With `long_mode` low there are four channels. The source address on the bus is `{PERIPH_HI, offset}`, and the 8-bit offset wraps within the window when it steps.
- R4: With `long_mode` high there are two channels, 0 and 1, each with a 24-bit source address. Channels 2 and 3 are never granted, whatever `req` does, and writes addressed to them are ignored.
- R5: After each completed move, an address that is not fixed steps by 1 for byte moves and by 2 for word moves. A fixed address keeps its value.
- R6: A channel that was programmed with count N completes exactly N moves. It then clears its enable bit and sets its `done` bit.
- R7: In repeat mode, completing the last move reloads the saved start source, destination and count. The channel stays enabled and `done` stays 0.
- R8: Among channels that are enabled and have `req` high, the lowest index wins. Each grant carries exactly one move, and a grant is made only in a cycle with no outstanding command, so `mem_valid` is low for one cycle after each handshake.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid` and all command fields hold their values.
- R10: `mem_word` equals the winning channel's word bit, and `mem_ch` gives its logical channel index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| long_mode | input | 1 | 1: two long channels, 0: four short channels |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Logical channel of the write |
| cfg_field | input | 2 | Field select of the write |
| cfg_data | input | 24 | Write data |
| req | input | 4 | Per-channel transfer request |
| mem_valid | output | 1 | Move command valid |
| mem_ready | input | 1 | Bus accepts the move |
| mem_src | output | 24 | Source byte address |
| mem_dst | output | 24 | Destination byte address |
| mem_word | output | 1 | 1: word move, 0: byte move |
| mem_ch | output | 2 | Channel that issued the command |
| done | output | 4 | Per-channel completion flags |

## Verification
The assertions check the properties that hold on every cycle. A command held under back-pressure must not change. A handshake must always be followed by an idle cycle. In short mode every source address must fall inside the peripheral window. A done flag may rise only right after a handshake from its own channel. In long mode channels 2 and 3 must never complete a move. The bench's scenarios are the only way to show the outcomes that depend on a whole sequence. These are the exact addresses after byte and word steps, including the wrap at the edge of the window and at 24 bits. They also include the count of moves before done is set, the reload in repeat mode, priority between channels that request together, and the same storage being reused when the layout is switched.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    FLD_SRC = 2'd0,
    FLD_DST = 2'd1,
    FLD_CNT = 2'd2,
    FLD_CTL = 2'd3
  } field_e;

  typedef struct packed {
    logic rpt;
    logic fix_dst;
    logic fix_src;
    logic word;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/dmac_arbiter.sv
module dmac_arbiter #(
  parameter int N = 4,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] elig,
  output logic [W-1:0] idx,
  output logic         any
);
  logic [N-1:0] grant;

  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = i[W-1:0];
      end
    end
  end

  assign any = |grant;

  // R8: a single winner at most
  always_comb begin
    a_r8_grant_onehot: assert ($onehot0(grant));
  end
endmodule

// File: rtl/dmac_regpool.sv
module dmac_regpool
  import dmac_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int AW = 24,
  parameter int SW = 8,
  parameter int CW = 16,
  parameter logic [AW-SW-1:0] PERIPH_HI = '1,
  localparam int CHW = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             long_mode,
  input  logic             wr_en,
  input  logic [CHW-1:0]   wr_ch,
  input  field_e           wr_field,
  input  logic [AW-1:0]    wr_data,
  input  logic             adv_valid,
  input  logic [CHW-1:0]   adv_ch,
  output logic [AW-1:0]    view_src [NSLOT],
  output logic [AW-1:0]    view_dst [NSLOT],
  output ctrl_t            view_ctl [NSLOT],
  output logic [NSLOT-1:0] done_q
);
  localparam int NLONG = NSLOT / 2;
  localparam int CTLW  = $bits(ctrl_t);

  logic [SW-1:0] s_src [NSLOT], sh_src [NSLOT], n_src [NSLOT], n_shs [NSLOT];
  logic [AW-1:0] s_dst [NSLOT], sh_dst [NSLOT], n_dst [NSLOT], n_shd [NSLOT];
  logic [CW-1:0] s_cnt [NSLOT], sh_cnt [NSLOT], n_cnt [NSLOT], n_shc [NSLOT];
  ctrl_t         s_ctl [NSLOT], n_ctl [NSLOT];
  logic [NSLOT-1:0] n_done;

  // Logical channel views over the slot pool
  for (genvar c = 0; c < NSLOT; c++) begin : g_view
    if (c < NLONG) begin : g_pair
      always_comb begin
        if (long_mode) begin
          view_src[c] = s_dst[2*c+1];
          view_dst[c] = s_dst[2*c];
          view_ctl[c] = s_ctl[2*c];
        end else begin
          view_src[c] = {PERIPH_HI, s_src[c]};
          view_dst[c] = s_dst[c];
          view_ctl[c] = s_ctl[c];
        end
      end
    end else begin : g_solo
      always_comb begin
        view_src[c] = {PERIPH_HI, s_src[c]};
        view_dst[c] = s_dst[c];
        view_ctl[c] = s_ctl[c];
        if (long_mode) view_ctl[c].en = 1'b0;
      end
    end
  end

  ctrl_t          a_ctl;
  logic [AW-1:0]  step;
  logic [CHW-1:0] dslot, sslot, wslot;
  logic           terminal;

  always_comb begin
    n_src = s_src;  n_dst = s_dst;  n_cnt = s_cnt;  n_ctl = s_ctl;
    n_shs = sh_src; n_shd = sh_dst; n_shc = sh_cnt; n_done = done_q;
    a_ctl    = view_ctl[adv_ch];
    step     = a_ctl.word ? AW'(2) : AW'(1);
    dslot    = long_mode ? {adv_ch[CHW-2:0], 1'b0} : adv_ch;
    sslot    = dslot | CHW'(1);
    terminal = (s_cnt[dslot] == CW'(1));
    wslot    = long_mode ? {wr_ch[CHW-2:0], 1'b0} : wr_ch;

    if (adv_valid) begin
      if (!a_ctl.fix_dst) n_dst[dslot] = s_dst[dslot] + step;
      if (!a_ctl.fix_src) begin
        if (long_mode) n_dst[sslot] = s_dst[sslot] + step;
        else           n_src[dslot] = s_src[dslot] + step[SW-1:0];
      end
      n_cnt[dslot] = s_cnt[dslot] - CW'(1);
      if (terminal) begin
        if (a_ctl.rpt) begin
          n_cnt[dslot] = sh_cnt[dslot];
          n_dst[dslot] = sh_dst[dslot];
          if (long_mode) n_dst[sslot] = sh_dst[sslot];
          else           n_src[dslot] = sh_src[dslot];
        end else begin
          n_ctl[dslot].en = 1'b0;
          n_done[adv_ch]  = 1'b1;
        end
      end
    end

    if (wr_en && (!long_mode || wr_ch < CHW'(NLONG))) begin
      unique case (wr_field)
        FLD_SRC: begin
          if (long_mode) begin
            n_dst[wslot | CHW'(1)] = wr_data;
            n_shd[wslot | CHW'(1)] = wr_data;
          end else begin
            n_src[wslot] = wr_data[SW-1:0];
            n_shs[wslot] = wr_data[SW-1:0];
          end
        end
        FLD_DST: begin
          n_dst[wslot] = wr_data;
          n_shd[wslot] = wr_data;
        end
        FLD_CNT: begin
          n_cnt[wslot] = wr_data[CW-1:0];
          n_shc[wslot] = wr_data[CW-1:0];
        end
        FLD_CTL: begin
          n_ctl[wslot]  = ctrl_t'(wr_data[CTLW-1:0]);
          n_done[wr_ch] = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_src  <= '{default: '0};
      s_dst  <= '{default: '0};
      s_cnt  <= '{default: '0};
      s_ctl  <= '{default: '0};
      sh_src <= '{default: '0};
      sh_dst <= '{default: '0};
      sh_cnt <= '{default: '0};
      done_q <= '0;
    end else begin
      s_src  <= n_src;
      s_dst  <= n_dst;
      s_cnt  <= n_cnt;
      s_ctl  <= n_ctl;
      sh_src <= n_shs;
      sh_dst <= n_shd;
      sh_cnt <= n_shc;
      done_q <= n_done;
    end
  end

  // R4: the upper channels never complete a move in the long layout
  a_r4_long_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_valid && long_mode) |-> (adv_ch < CHW'(NLONG)));

  for (genvar c = 0; c < NSLOT; c++) begin : g_chk
    // R6: a done flag rises only right after a move of its own channel
    a_r6_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q[c]) |-> ($past(adv_valid) && ($past(adv_ch) == CHW'(c))));
  end
endmodule

// File: rtl/dmac_pool.sv
module dmac_pool
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW = 24,
  parameter int SW = 8,
  parameter int CW = 16,
  parameter logic [AW-SW-1:0] PERIPH_HI = 16'hFF00,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           long_mode,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_field,
  input  logic [AW-1:0]  cfg_data,
  input  logic [NCH-1:0] req,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [AW-1:0]  mem_src,
  output logic [AW-1:0]  mem_dst,
  output logic           mem_word,
  output logic [CHW-1:0] mem_ch,
  output logic [NCH-1:0] done
);
  logic [AW-1:0]  view_src [NCH];
  logic [AW-1:0]  view_dst [NCH];
  ctrl_t          view_ctl [NCH];
  logic [NCH-1:0] elig;
  logic [CHW-1:0] gidx;
  logic           gany;
  logic           adv_valid;

  assign adv_valid = mem_valid & mem_ready;

  dmac_regpool #(
    .NSLOT(NCH), .AW(AW), .SW(SW), .CW(CW), .PERIPH_HI(PERIPH_HI)
  ) u_pool (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
    .wr_en(cfg_we), .wr_ch(cfg_ch), .wr_field(field_e'(cfg_field)),
    .wr_data(cfg_data), .adv_valid(adv_valid), .adv_ch(mem_ch),
    .view_src(view_src), .view_dst(view_dst), .view_ctl(view_ctl),
    .done_q(done)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_elig
    assign elig[c] = view_ctl[c].en & req[c];
  end

  dmac_arbiter #(.N(NCH)) u_arb (.elig(elig), .idx(gidx), .any(gany));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_src   <= '0;
      mem_dst   <= '0;
      mem_word  <= 1'b0;
      mem_ch    <= '0;
    end else if (mem_valid) begin
      if (mem_ready) mem_valid <= 1'b0;
    end else if (gany) begin
      mem_valid <= 1'b1;
      mem_src   <= view_src[gidx];
      mem_dst   <= view_dst[gidx];
      mem_word  <= view_ctl[gidx].word;
      mem_ch    <= gidx;
    end
  end

  // R9: command frozen under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_src) &&
      $stable(mem_dst) && $stable(mem_word) && $stable(mem_ch)));

  // R8: one idle cycle after every handshake
  a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> !mem_valid);

  // R3: short-layout sources stay inside the peripheral window
  a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !long_mode) |-> (mem_src[AW-1:SW] == PERIPH_HI));
endmodule

// File: tb/dmac_pool_tb.sv
module dmac_pool_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PHI = 16'h00E0;

  logic clk = 1'b0, rst_n = 1'b0, long_mode = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0, cfg_field = '0;
  logic [23:0] cfg_data = '0;
  logic [3:0] req = '0;
  logic mem_ready = 1'b1, mem_valid, mem_word;
  logic [23:0] mem_src, mem_dst;
  logic [1:0] mem_ch;
  logic [3:0] done;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_pool #(.PERIPH_HI(PHI)) u_dut (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode), .cfg_we(cfg_we),
    .cfg_ch(cfg_ch), .cfg_field(cfg_field), .cfg_data(cfg_data), .req(req),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_src(mem_src),
    .mem_dst(mem_dst), .mem_word(mem_word), .mem_ch(mem_ch), .done(done));

  int compared = 0, mismatched = 0, cyc = 0, bad_grants = 0;
  bit finished = 0, rdy_rand = 0;
  logic [7:0] lfsr = 8'h5A;

  // Behavioural reference: one record per logical channel
  int m_src[4], m_dst[4], m_cnt[4], sv_src[4], sv_dst[4], sv_cnt[4];
  bit m_en[4], m_word[4], m_fs[4], m_fd[4], m_rpt[4], m_done[4];
  bit m_valid = 0, m_w = 0;
  int m_s = 0, m_d = 0, m_ch = 0;

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic model_step(input int c);
    int inc;
    inc = m_word[c] ? 2 : 1;
    if (!m_fd[c]) m_dst[c] = (m_dst[c] + inc) & 24'hFFFFFF;
    if (!m_fs[c]) m_src[c] = long_mode ? ((m_src[c] + inc) & 24'hFFFFFF) : ((m_src[c] + inc) & 8'hFF);
    if (m_cnt[c] == 1) begin
      if (m_rpt[c]) begin
        m_src[c] = sv_src[c]; m_dst[c] = sv_dst[c]; m_cnt[c] = sv_cnt[c];
      end else begin
        m_en[c] = 0; m_done[c] = 1; m_cnt[c] = 0;
      end
    end else m_cnt[c] = (m_cnt[c] - 1) & 16'hFFFF;
  endtask

  always @(posedge clk) begin
    bit found;
    int d, ch;
    found = 0;
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_src[c] = 0; m_dst[c] = 0; m_cnt[c] = 0; sv_src[c] = 0; sv_dst[c] = 0; sv_cnt[c] = 0;
        m_en[c] = 0; m_word[c] = 0; m_fs[c] = 0; m_fd[c] = 0; m_rpt[c] = 0; m_done[c] = 0;
      end
      m_valid = 0;
    end else begin
      if (m_valid) begin
        if (mem_ready) begin model_step(m_ch); m_valid = 0; end
      end else begin
        for (int c = 0; c < (long_mode ? 2 : 4); c++) begin
          if (!found && m_en[c] && req[c]) begin
            found = 1; m_valid = 1; m_ch = c; m_w = m_word[c]; m_d = m_dst[c];
            m_s = long_mode ? m_src[c] : ((int'(PHI) << 8) | m_src[c]);
          end
        end
      end
      if (cfg_we && (!long_mode || cfg_ch < 2)) begin
        d = int'(cfg_data); ch = int'(cfg_ch);
        case (cfg_field)
          2'd0: begin m_src[ch] = long_mode ? d : (d & 8'hFF); sv_src[ch] = m_src[ch]; end
          2'd1: begin m_dst[ch] = d; sv_dst[ch] = d; end
          2'd2: begin m_cnt[ch] = d & 16'hFFFF; sv_cnt[ch] = m_cnt[ch]; end
          default: begin
            m_en[ch] = d[0]; m_word[ch] = d[1]; m_fs[ch] = d[2]; m_fd[ch] = d[3];
            m_rpt[ch] = d[4]; m_done[ch] = 0;
          end
        endcase
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    int dv;
    if (rst_n && !finished) begin
      dv = 0;
      for (int c = 0; c < 4; c++) dv |= (m_done[c] << c);
      check("R9 mem_valid", int'(mem_valid), int'(m_valid));
      check("R6 done", int'(done), dv);
      if (m_valid && mem_valid) begin
        check("R3 mem_src", int'(mem_src), m_s);
        check("R5 mem_dst", int'(mem_dst), m_d);
        check("R8 mem_ch", int'(mem_ch), m_ch);
        check("R10 mem_word", int'(mem_word), int'(m_w));
      end
      if (long_mode && mem_valid && mem_ch >= 2) bad_grants++;
    end
  end

  always @(negedge clk) begin
    if (rdy_rand) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = lfsr[0];
    end else mem_ready = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL R9 watchdog: actual %0d cycles expected below 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wr(input int ch, input int f, input int d);
    cfg_ch = ch[1:0]; cfg_field = f[1:0]; cfg_data = d[23:0]; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int ch, input int s, input int d, input int n, input int ctl);
    wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, n); wr(ch, 3, ctl);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset mem_valid", int'(mem_valid), 0);
    check("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(mem_valid), 0);

    // Short layout: byte channel with window wrap (R3, R5, R6)
    prog(1, 'hFE, 'h001000, 3, 'h01);
    req = 4'b0010;
    repeat (20) @(negedge clk);
    check("R6 ch1 done after three moves", int'(done[1]), 1);
    req = 4'b0000;
    wr(1, 3, 'h00);
    check("R2 control write clears done", int'(done[1]), 0);

    // Priority between two word channels under back-pressure (R8, R9, R5)
    prog(0, 'h10, 'h002000, 4, 'h03);
    prog(2, 'h40, 'h003000, 3, 'h0B);
    rdy_rand = 1;
    req = 4'b0101;
    repeat (80) @(negedge clk);
    check("R8 both channels finished", int'(done & 4'b0101), 'b0101);
    req = 4'b0000;
    rdy_rand = 0;

    // Repeat with fixed source (R7)
    prog(3, 'h80, 'h004000, 2, 'h15);
    req = 4'b1000;
    repeat (30) @(negedge clk);
    check("R7 repeat never sets done", int'(done[3]), 0);
    req = 4'b0000;
    repeat (4) @(negedge clk);
    wr(3, 3, 'h00);
    repeat (2) @(negedge clk);

    // Long layout (R4)
    long_mode = 1'b1;
    @(negedge clk);
    prog(0, 'h123456, 'h00ABCD, 3, 'h0B);
    prog(1, 'hFFFFFE, 'h500000, 3, 'h01);
    wr(2, 3, 'h01);
    req = 4'b1111;
    repeat (40) @(negedge clk);
    check("R4 long channels done", int'(done[1:0]), 'b11);
    check("R4 no grant to upper channels", bad_grants, 0);
    check("R4 write to channel 2 ignored", int'(done[2]), 1);
    req = 4'b0000;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule